// File: doc/BRIEF.md
# Oscillation Stabilization Wait Controller

This block sequences reset release and clock recovery for a small microcontroller clock unit. It holds a 2-bit wait-select setting and a free-running timebase counter. Whenever a stabilization wait is needed, it clears the counter and holds the device until the counter reaches the interval that the setting selects. It produces three results: a settings-initialization reset, an operation-initialization reset and a "running" indication.

Each reset cause gets its own treatment. A release of the external initialization pin is always followed by a wait. A watchdog request waits only when the subclock is the source and the main oscillator is switched off; otherwise it goes straight through a short operation-reset phase. An abnormal PLL condition while the PLL is the source stops normal running for one wait interval but asserts neither reset. The wait-select setting survives watchdog resets and is cleared only by the pin.

Top module: `oscwait_ctrl`

## Requirements
- R1: The wait-select field `reg_wdata[1:0]` picks the wait length from parameters: code 00 uses bit position WAIT_POS_NONE, 01 WAIT_POS_PLL, 10 WAIT_POS_MID and 11 WAIT_POS_LONG. A wait starts with the timebase counter at zero and ends in the cycle after the counter reaches 2^position.
- R2: `init_pin` passes through a two-flip-flop synchronizer. While the synchronized pin is high, `sinit_rst` and `op_rst` are high, `running` is low, and the wait-select field returns to 11.
- R3: After the pin is released, `sinit_rst` falls and a stabilization wait follows with `op_rst` held high, using the currently selected length.
- R4: A watchdog request raises `sinit_rst` for exactly one cycle and leaves the programmed wait-select value unchanged.
- R5: After a watchdog request with `clk_src` = 01 (subclock) and `main_osc_off` = 1, a stabilization wait follows the settings-initialization reset.
- R6: After a watchdog request with `clk_src` = 00 (main), or with `clk_src` = 01 and `main_osc_off` = 0, no wait is inserted: `op_rst` is held for one cycle and the block then runs.
- R7: `pll_fault` while running with `clk_src` = 10 (PLL) drops `running` for one wait interval without asserting either reset, and running resumes afterwards. With any other source, `pll_fault` has no effect.
- R8: A new wait source during an ongoing wait restarts the counter from zero.
- R9: The synchronized pin takes priority over watchdog and PLL events. While it is high, these events neither release the resets nor keep the setting from returning to 11.
- R10: A write on `reg_wr` takes effect only while `running` is high. Writes at other times are ignored.
- R11: `op_rst` stays high for one more cycle after a wait ends and is then released straight into running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| init_pin | input | 1 | External initialization pin, active high, asynchronous |
| wdt_req | input | 1 | Watchdog reset request, one-cycle pulse |
| clk_src | input | 2 | Clock source: 00 main, 01 subclock, 10 PLL |
| main_osc_off | input | 1 | Main oscillator disabled |
| pll_fault | input | 1 | PLL abnormal condition |
| reg_wr | input | 1 | Write strobe for the wait-select field |
| reg_wdata | input | 2 | Wait-select write data |
| sinit_rst | output | 1 | Settings-initialization reset |
| op_rst | output | 1 | Operation-initialization reset |
| running | output | 1 | Normal running indication |

## Verification
Inputs change on the falling edge. Counting from that edge:
- A watchdog or PLL event changes the outputs one cycle later.
- A wait lasts 2^position + 1 cycles with the counter starting at zero, and running resumes one cycle after the wait for a PLL wait, or two cycles after it following a reset wait.
- A pin edge needs two synchronizer cycles before the sequencer sees it, so the first wait cycle appears three cycles after the pin falls.

The driver queues one expected output triple for each of these cycle numbers, and a monitor compares the outputs against the queue one nanosecond after each rising edge. The wait-select setting is observed only through the length of the next wait.

// File: rtl/oscwait_pkg.sv
package oscwait_pkg;

   typedef enum logic [2:0] {
      ST_PIN_INIT  = 3'd0,
      ST_WDT_INIT  = 3'd1,
      ST_RST_WAIT  = 3'd2,
      ST_RST_HOLD  = 3'd3,
      ST_RUN       = 3'd4,
      ST_PLL_WAIT  = 3'd5
   } seq_state_e;

   localparam logic [1:0] SRC_MAIN = 2'b00;
   localparam logic [1:0] SRC_SUB  = 2'b01;
   localparam logic [1:0] SRC_PLL  = 2'b10;

   localparam logic [1:0] WSEL_DEFAULT = 2'b11;

endpackage

// File: rtl/oscwait_sync.sv
module oscwait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("oscwait_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/oscwait_timebase.sv
module oscwait_timebase #(
   parameter int POS_NONE = 0,
   parameter int POS_PLL  = 9,
   parameter int POS_MID  = 13,
   parameter int POS_LONG = 17
) (
   input  logic       clk,
   input  logic       clr,
   input  logic [1:0] sel,
   output logic       expired
);

   localparam int POS_TAB [4] = '{POS_NONE, POS_PLL, POS_MID, POS_LONG};
   localparam int MAX_A  = (POS_NONE > POS_PLL) ? POS_NONE : POS_PLL;
   localparam int MAX_B  = (POS_MID > POS_LONG) ? POS_MID : POS_LONG;
   localparam int MAXPOS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CNT_W  = MAXPOS + 1;
   localparam int IDX_W  = (CNT_W > 1) ? $clog2(CNT_W) : 1;

   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] pos_of [4];

   genvar g;
   generate
      for (g = 0; g < 4; g++) begin : g_pos
         assign pos_of[g] = IDX_W'(POS_TAB[g]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr) cnt <= '0;
      else     cnt <= cnt + 1'b1;
   end

   assign expired = cnt[pos_of[sel]];

endmodule

// File: rtl/oscwait_seq.sv
module oscwait_seq
   import oscwait_pkg::*;
(
   input  logic       clk,
   input  logic       init_s,
   input  logic       wdt_req,
   input  logic [1:0] clk_src,
   input  logic       main_osc_off,
   input  logic       pll_fault,
   input  logic       reg_wr,
   input  logic [1:0] reg_wdata,
   input  logic       expired,
   output logic       tb_clr,
   output logic [1:0] wait_sel,
   output logic       sinit_rst,
   output logic       op_rst,
   output logic       running
);

   seq_state_e state, state_nxt;
   logic       pll_evt;

   assign pll_evt = pll_fault && (clk_src == SRC_PLL);

   always_comb begin
      state_nxt = state;
      tb_clr    = 1'b0;
      if (init_s) begin
         state_nxt = ST_PIN_INIT;
         tb_clr    = 1'b1;
      end else if (wdt_req) begin
         state_nxt = ST_WDT_INIT;
      end else begin
         unique case (state)
            ST_PIN_INIT: begin
               state_nxt = ST_RST_WAIT;
               tb_clr    = 1'b1;
            end
            ST_WDT_INIT: begin
               if ((clk_src == SRC_SUB) && main_osc_off) begin
                  state_nxt = ST_RST_WAIT;
                  tb_clr    = 1'b1;
               end else begin
                  state_nxt = ST_RST_HOLD;
               end
            end
            ST_RST_WAIT: if (expired) state_nxt = ST_RST_HOLD;
            ST_RST_HOLD: state_nxt = ST_RUN;
            ST_RUN: begin
               if (pll_evt) begin
                  state_nxt = ST_PLL_WAIT;
                  tb_clr    = 1'b1;
               end
            end
            ST_PLL_WAIT: begin
               if (pll_evt)      tb_clr    = 1'b1;
               else if (expired) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_PIN_INIT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      state <= state_nxt;
   end

   always_ff @(posedge clk) begin
      if (init_s)                          wait_sel <= WSEL_DEFAULT;
      else if (reg_wr && state == ST_RUN)  wait_sel <= reg_wdata;
   end

   assign sinit_rst = (state == ST_PIN_INIT) || (state == ST_WDT_INIT);
   assign op_rst    = sinit_rst || (state == ST_RST_WAIT) || (state == ST_RST_HOLD);
   assign running   = (state == ST_RUN);

endmodule

// File: rtl/oscwait_ctrl.sv
module oscwait_ctrl #(
   parameter int SYNC_STAGES   = 2,
   parameter int WAIT_POS_NONE = 0,
   parameter int WAIT_POS_PLL  = 9,
   parameter int WAIT_POS_MID  = 13,
   parameter int WAIT_POS_LONG = 17
) (
   input  logic       clk,
   input  logic       init_pin,
   input  logic       wdt_req,
   input  logic [1:0] clk_src,
   input  logic       main_osc_off,
   input  logic       pll_fault,
   input  logic       reg_wr,
   input  logic [1:0] reg_wdata,
   output logic       sinit_rst,
   output logic       op_rst,
   output logic       running
);

   generate
      if (WAIT_POS_NONE < 0 || WAIT_POS_NONE > 30 ||
          WAIT_POS_PLL  < 0 || WAIT_POS_PLL  > 30 ||
          WAIT_POS_MID  < 0 || WAIT_POS_MID  > 30 ||
          WAIT_POS_LONG < 0 || WAIT_POS_LONG > 30) begin : g_bad_pos
         $error("oscwait_ctrl: wait bit positions must lie in 0..30");
      end
   endgenerate

   logic       init_s;
   logic       tb_clr;
   logic       expired;
   logic [1:0] wait_sel;

   oscwait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   (init_pin),
      .q   (init_s)
   );

   oscwait_timebase #(
      .POS_NONE (WAIT_POS_NONE),
      .POS_PLL  (WAIT_POS_PLL),
      .POS_MID  (WAIT_POS_MID),
      .POS_LONG (WAIT_POS_LONG)
   ) u_tb (
      .clk     (clk),
      .clr     (tb_clr),
      .sel     (wait_sel),
      .expired (expired)
   );

   oscwait_seq u_seq (
      .clk          (clk),
      .init_s       (init_s),
      .wdt_req      (wdt_req),
      .clk_src      (clk_src),
      .main_osc_off (main_osc_off),
      .pll_fault    (pll_fault),
      .reg_wr       (reg_wr),
      .reg_wdata    (reg_wdata),
      .expired      (expired),
      .tb_clr       (tb_clr),
      .wait_sel     (wait_sel),
      .sinit_rst    (sinit_rst),
      .op_rst       (op_rst),
      .running      (running)
   );

endmodule

// File: rtl/oscwait_ctrl_chk.sv
module oscwait_ctrl_chk (
   input logic       clk,
   input logic       init_s,
   input logic       wdt_req,
   input logic [1:0] clk_src,
   input logic       main_osc_off,
   input logic       pll_fault,
   input logic [1:0] wait_sel,
   input logic       sinit_rst,
   input logic       op_rst,
   input logic       running
);

   logic armed = 1'b0;

   always_ff @(posedge clk) begin
      if (init_s) armed <= 1'b1;
   end

   // R2: synchronized pin forces both resets on the next cycle
   a_r2_pin_holds: assert property (@(posedge clk) disable iff (!armed)
      init_s |=> (sinit_rst && op_rst && !running));

   // R3: settings reset always hands over to operation reset
   a_r3_sinit_to_rst: assert property (@(posedge clk) disable iff (!armed || init_s)
      $fell(sinit_rst) |-> op_rst);

   // R4: watchdog while running enters settings reset
   a_r4_wdt_enters: assert property (@(posedge clk) disable iff (!armed || init_s)
      (running && wdt_req) |=> (sinit_rst && op_rst && !running));

   // R4, R10: setting never moves outside running
   a_r4_sel_kept: assert property (@(posedge clk) disable iff (!armed || init_s)
      !running |=> $stable(wait_sel));

   // R5: subclock with main oscillator off goes into a reset wait
   a_r5_sub_wait: assert property (@(posedge clk) disable iff (!armed || init_s)
      (sinit_rst && !wdt_req && clk_src == 2'b01 && main_osc_off)
      |=> (op_rst && !sinit_rst && !running));

   // R7: PLL fault while on PLL stops running without reset
   a_r7_pll_wait: assert property (@(posedge clk) disable iff (!armed || init_s)
      (running && pll_fault && !wdt_req && clk_src == 2'b10)
      |=> (!running && !op_rst && !sinit_rst));

   // R11: operation reset is released straight into running
   a_r11_rst_release: assert property (@(posedge clk) disable iff (!armed || init_s)
      $fell(op_rst) |-> running);

endmodule

bind oscwait_ctrl oscwait_ctrl_chk u_chk (
   .clk          (clk),
   .init_s       (init_s),
   .wdt_req      (wdt_req),
   .clk_src      (clk_src),
   .main_osc_off (main_osc_off),
   .pll_fault    (pll_fault),
   .wait_sel     (wait_sel),
   .sinit_rst    (sinit_rst),
   .op_rst       (op_rst),
   .running      (running)
);

// File: tb/oscwait_ctrl_tb.sv
`timescale 1ns/1ps
module oscwait_ctrl_tb;

   localparam int P0 = 0, P1 = 3, P2 = 5, P3 = 7;
   localparam int L0 = 1 << P0, L1 = 1 << P1, L2 = 1 << P2, L3 = 1 << P3;

   logic       clk = 1'b0;
   logic       init_pin = 1'b1;
   logic       wdt_req = 1'b0;
   logic [1:0] clk_src = 2'b00;
   logic       main_osc_off = 1'b0;
   logic       pll_fault = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_wdata = 2'b00;
   logic       sinit_rst, op_rst, running;

   always #2 clk = ~clk;

   oscwait_ctrl #(
      .SYNC_STAGES(2), .WAIT_POS_NONE(P0), .WAIT_POS_PLL(P1),
      .WAIT_POS_MID(P2), .WAIT_POS_LONG(P3)
   ) u_dut (
      .clk(clk), .init_pin(init_pin), .wdt_req(wdt_req), .clk_src(clk_src),
      .main_osc_off(main_osc_off), .pll_fault(pll_fault), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .sinit_rst(sinit_rst), .op_rst(op_rst),
      .running(running)
   );

   int         cyc = 0;
   int         n_cmp = 0;
   int         n_bad = 0;
   bit         done = 1'b0;
   int         q_cyc [$];
   logic [2:0] q_val [$];
   string      q_req [$];

   // expected value order: {sinit_rst, op_rst, running}
   task automatic push(int c, logic [2:0] v, string r);
      q_cyc.push_back(c);
      q_val.push_back(v);
      q_req.push_back(r);
   endtask

   task automatic push_span(int a, int b, logic [2:0] v, string r);
      for (int k = a; k <= b; k++) push(k, v, r);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_until(int c);
      while (cyc < c) @(negedge clk);
   endtask

   // monitor: samples 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            n_cmp++;
            if (q_cyc[0] != cyc || {sinit_rst, op_rst, running} != q_val[0]) begin
               n_bad++;
               $display("FAIL %s cycle %0d: actual %b expected %b (due %0d)",
                        q_req[0], cyc, {sinit_rst, op_rst, running}, q_val[0], q_cyc[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_val.pop_front());
            void'(q_req.pop_front());
         end
      end
   end

   // a PLL fault event while running; wait length len
   task automatic pll_event(int len, string r);
      int n;
      n = cyc;
      push_span(n + 1, n + 1 + len, 3'b000, r);
      push_span(n + 2 + len, n + 4 + len, 3'b001, r);
      pll_fault = 1'b1;
      step(1);
      pll_fault = 1'b0;
      wait_until(n + 4 + len);
   endtask

   // a watchdog event while running
   task automatic wdt_event(bit waits, int len, string r);
      int n;
      n = cyc;
      push(n + 1, 3'b110, r);
      if (waits) begin
         push_span(n + 2, n + 3 + len, 3'b010, r);
         push_span(n + 4 + len, n + 6 + len, 3'b001, r);
      end else begin
         push(n + 2, 3'b010, r);
         push_span(n + 3, n + 5, 3'b001, r);
      end
      wdt_req = 1'b1;
      step(1);
      wdt_req = 1'b0;
      wait_until(waits ? n + 6 + len : n + 5);
   endtask

   task automatic write_sel(logic [1:0] code);
      push(cyc + 1, 3'b001, "R10");
      reg_wr = 1'b1;
      reg_wdata = code;
      step(1);
      reg_wr = 1'b0;
      step(1);
   endtask

   task automatic pin_release(string r);
      int n;
      n = cyc;
      push_span(n + 1, n + 2, 3'b110, r);
      push_span(n + 3, n + 4 + L3, 3'b010, r);
      push_span(n + 5 + L3, n + 7 + L3, 3'b001, r);
      init_pin = 1'b0;
      wait_until(n + 7 + L3);
   endtask

   initial begin
      int n;
      step(3);
      // R2: reset state while the pin is high
      n = cyc;
      push_span(n + 1, n + 3, 3'b110, "R2");
      wait_until(n + 3);

      // R3, R1 (code 11): release runs the long default wait
      pin_release("R3");

      // R7, R1: PLL fault on PLL source with default code 11
      clk_src = 2'b10;
      pll_event(L3, "R7");

      // R10, R1: code 01 selects the PLL lock length
      write_sel(2'b01);
      pll_event(L1, "R1");

      // R6, R4: watchdog on main clock, no wait; setting kept
      clk_src = 2'b00;
      wdt_event(1'b0, 0, "R6");
      clk_src = 2'b10;
      pll_event(L1, "R4");

      // R6: subclock with oscillator running, no wait
      clk_src = 2'b01;
      main_osc_off = 1'b0;
      wdt_event(1'b0, 0, "R6");

      // R5, R11: subclock with oscillator off waits (code 10);
      // R10: a write during that wait is ignored
      write_sel(2'b10);
      main_osc_off = 1'b1;
      n = cyc;
      push(n + 1, 3'b110, "R5");
      push_span(n + 2, n + 3 + L2, 3'b010, "R5");
      push(n + 4 + L2, 3'b001, "R11");
      push_span(n + 5 + L2, n + 6 + L2, 3'b001, "R11");
      wdt_req = 1'b1;
      step(1);
      wdt_req = 1'b0;
      step(5);
      reg_wr = 1'b1;
      reg_wdata = 2'b00;
      step(1);
      reg_wr = 1'b0;
      wait_until(n + 6 + L2);
      main_osc_off = 1'b0;
      clk_src = 2'b10;
      pll_event(L2, "R10");

      // R8: second PLL fault restarts the wait from zero
      n = cyc;
      push_span(n + 1, n + 11 + L2, 3'b000, "R8");
      push_span(n + 12 + L2, n + 14 + L2, 3'b001, "R8");
      pll_fault = 1'b1;
      step(1);
      pll_fault = 1'b0;
      wait_until(n + 10);
      pll_fault = 1'b1;
      step(1);
      pll_fault = 1'b0;
      wait_until(n + 14 + L2);

      // R7: PLL fault with main source has no effect
      clk_src = 2'b00;
      n = cyc;
      push_span(n + 1, n + 6, 3'b001, "R7");
      pll_fault = 1'b1;
      step(1);
      pll_fault = 1'b0;
      wait_until(n + 6);

      // R1: code 00, shortest wait
      clk_src = 2'b10;
      write_sel(2'b00);
      pll_event(L0, "R1");

      // R9: pin wins over watchdog and PLL events, setting returns to 11
      clk_src = 2'b00;
      n = cyc;
      push_span(n + 1, n + 2, 3'b001, "R9");
      push_span(n + 3, n + 14, 3'b110, "R9");
      init_pin = 1'b1;
      step(5);
      wdt_req = 1'b1;
      step(1);
      wdt_req = 1'b0;
      clk_src = 2'b10;
      pll_fault = 1'b1;
      step(1);
      pll_fault = 1'b0;
      wait_until(n + 14);
      pin_release("R2");

      step(2);
      done = 1'b1;
   end

   initial begin
      int t;
      t = 0;
      while (!done && t < 20000) begin
         @(posedge clk);
         t++;
      end
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule